// File: doc/BRIEF.md
# Host Memory Address Router

This block steers every memory cycle seen on the host bus to exactly one destination: main DRAM, the PCI side, or a local termination that consumes the cycle. Each cycle arrives with its address, its direction (read or write) and a flag that says whether a bus master started it rather than the host processor. One clock after the request strobe, the router presents its verdict. The verdict is a two-bit destination code plus a flag that tells the data path to return zeros.

The decision rests on a small register file that software writes through a simple indexed write port. The registers hold:

- the top of installed memory, in megabytes;
- an enable that opens the 512K–640K window to PCI;
- an enable, base and size for one hole in extended memory;
- a read-enable mask and a write-enable mask for the thirteen legacy ROM segments.

The ROM area is split into twelve 16 KB segments from C0000h to EFFFFh and one 64 KB segment at F0000h. Because reads and writes of a segment are steered on separate bits, software can first copy ROM into DRAM: reads go to PCI while writes land in DRAM. It then locks the DRAM copy read-only: reads come from DRAM and writes are sent away from it.

Top module: `mem_addr_router`

## Requirements
- R1: An address at or above 4 GB (any bit from 32 upward set) yields destination TERM (code 2). The zero flag is 1 for a read and 0 for a write.
- R2: Addresses 00000h–7FFFFh always yield DRAM (code 0).
- R3: Addresses 80000h–9FFFFh yield DRAM, or PCI (code 1) while the low-hole enable (register 1, bit 0) is set.
- R4: Addresses A0000h–BFFFFh always yield PCI.
- R5: In C0000h–EFFFFh the segment index is (address − C0000h) / 4000h, and F0000h–FFFFFh is segment 12. A host read goes to DRAM when bit <index> of the read mask (register 4) is set, otherwise to PCI.
- R6: A host write to a ROM segment goes to DRAM when bit <index> of the write mask (register 5) is set, otherwise to PCI. Read and write masks act independently, so copy phase (read PCI, write DRAM) and locked phase (read DRAM, write PCI) both exist.
- R7: Addresses from 1 MB up to, but not including, top of memory (register 0, in MB) yield DRAM. The exception is a megabyte inside the extended hole, which yields PCI. The hole is enabled by register 1, bit 1, and spans base (register 2, MB) up to, but not including, base plus size (register 3, MB). Addresses from top of memory up to 4 GB yield PCI.
- R8: A cycle with the master flag set that targets a ROM segment whose read or write bit is set yields NOCLAIM (code 3). All other master cycles route as host cycles do.
- R9: The response valid, destination and zero flag appear exactly one clock after the request strobe. The response valid is low one clock after a cycle without a strobe.
- R10: After reset both masks are clear, both holes are off and top of memory is 1 MB. A register write and a request in the same clock are decoded with the value held before the write.
- R11: The zero flag is never set with any destination other than TERM.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_idx | input | 3 | Register index (0 top, 1 hole enables, 2 hole base, 3 hole size, 4 read mask, 5 write mask) |
| cfg_wdata | input | CFG_W | Register write data |
| req_vld | input | 1 | Request strobe |
| req_addr | input | ADDR_W | Host-bus byte address |
| req_write | input | 1 | 1 for a write, 0 for a read |
| req_master | input | 1 | 1 when a PCI or ISA master started the cycle |
| rsp_vld | output | 1 | Response valid |
| rsp_dest | output | 2 | 0 DRAM, 1 PCI, 2 TERM, 3 NOCLAIM |
| rsp_zero | output | 1 | Return all-zero read data |

## Verification
A register write and a request can land on the same clock edge. In that case the request must see the setting from before the write. The bench provokes this by writing the low-hole enable in the very cycle it requests 90000h. It expects DRAM on that response, then requests the same address again on the next cycle and expects PCI. The register sweeps also alternate read and write cycles from host and master under copy-phase and locked-phase masks. This checks that the per-direction masks and master suppression resolve correctly when they meet on one segment.

// File: rtl/mar_pkg.sv
package mar_pkg;

  typedef enum logic [1:0] {
    DST_DRAM    = 2'd0,
    DST_PCI     = 2'd1,
    DST_TERM    = 2'd2,
    DST_NOCLAIM = 2'd3
  } dest_e;

  localparam int unsigned SEG_CNT = 13;

  localparam logic [2:0] REG_TOM   = 3'd0;
  localparam logic [2:0] REG_HOLE  = 3'd1;
  localparam logic [2:0] REG_XBASE = 3'd2;
  localparam logic [2:0] REG_XSIZE = 3'd3;
  localparam logic [2:0] REG_SHRD  = 3'd4;
  localparam logic [2:0] REG_SHWR  = 3'd5;

endpackage

// File: rtl/mar_cfg_regs.sv
module mar_cfg_regs
  import mar_pkg::*;
#(
  parameter int unsigned MB_W  = 12,
  parameter int unsigned SEG_N = 13,
  parameter int unsigned CFG_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [2:0]       cfg_idx,
  input  logic [CFG_W-1:0] cfg_wdata,
  output logic [MB_W-1:0]  tom,
  output logic             low_hole_en,
  output logic             xh_en,
  output logic [MB_W-1:0]  xh_base,
  output logic [MB_W-1:0]  xh_size,
  output logic [SEG_N-1:0] sh_rd,
  output logic [SEG_N-1:0] sh_wr
);

  localparam logic [MB_W-1:0] TOM_RST = MB_W'(1);

  logic [MB_W-1:0]  tom_q, tom_d;
  logic             lh_q, lh_d;
  logic             xe_q, xe_d;
  logic [MB_W-1:0]  xb_q, xb_d;
  logic [MB_W-1:0]  xs_q, xs_d;
  logic [SEG_N-1:0] rd_q, rd_d;
  logic [SEG_N-1:0] wr_q, wr_d;

  logic unused_cfg_bits;
  assign unused_cfg_bits = ^cfg_wdata;

  always_comb begin
    tom_d = tom_q;
    lh_d  = lh_q;
    xe_d  = xe_q;
    xb_d  = xb_q;
    xs_d  = xs_q;
    rd_d  = rd_q;
    wr_d  = wr_q;
    if (cfg_we) begin
      unique case (cfg_idx)
        REG_TOM:   tom_d = cfg_wdata[MB_W-1:0];
        REG_HOLE: begin
          lh_d = cfg_wdata[0];
          xe_d = cfg_wdata[1];
        end
        REG_XBASE: xb_d = cfg_wdata[MB_W-1:0];
        REG_XSIZE: xs_d = cfg_wdata[MB_W-1:0];
        REG_SHRD:  rd_d = cfg_wdata[SEG_N-1:0];
        REG_SHWR:  wr_d = cfg_wdata[SEG_N-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tom_q <= TOM_RST;
      lh_q  <= 1'b0;
      xe_q  <= 1'b0;
      xb_q  <= '0;
      xs_q  <= '0;
      rd_q  <= '0;
      wr_q  <= '0;
    end else if (cfg_we) begin
      tom_q <= tom_d;
      lh_q  <= lh_d;
      xe_q  <= xe_d;
      xb_q  <= xb_d;
      xs_q  <= xs_d;
      rd_q  <= rd_d;
      wr_q  <= wr_d;
    end
  end

  assign tom         = tom_q;
  assign low_hole_en = lh_q;
  assign xh_en       = xe_q;
  assign xh_base     = xb_q;
  assign xh_size     = xs_q;
  assign sh_rd       = rd_q;
  assign sh_wr       = wr_q;

  AST_MASK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_we |=> ($stable(rd_q) && $stable(wr_q) && $stable(tom_q))); // R10

endmodule

// File: rtl/mar_seg_decode.sv
module mar_seg_decode #(
  parameter int unsigned SEG_N = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [5:0]       seg_field,
  input  logic [SEG_N-1:0] sh_rd,
  input  logic [SEG_N-1:0] sh_wr,
  output logic             seg_any,
  output logic             seg_rd_en,
  output logic             seg_wr_en
);

  localparam int unsigned SMALL_N  = SEG_N - 1;
  localparam logic [5:0]  SMALL_LO = 6'h30;

  logic [SEG_N-1:0] hit;

  for (genvar gi = 0; gi < SMALL_N; gi++) begin : g_small
    localparam logic [5:0] TAG = SMALL_LO + 6'(gi);
    assign hit[gi] = (seg_field == TAG);
  end

  assign hit[SEG_N-1] = (seg_field[5:2] == 4'hF);

  assign seg_any   = |hit;
  assign seg_rd_en = |(hit & sh_rd);
  assign seg_wr_en = |(hit & sh_wr);

  AST_SEG_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit)); // R5

endmodule

// File: rtl/mar_ext_cmp.sv
module mar_ext_cmp #(
  parameter int unsigned MB_W = 12
) (
  input  logic [MB_W-1:0] mb,
  input  logic [MB_W-1:0] tom,
  input  logic            xh_en,
  input  logic [MB_W-1:0] xh_base,
  input  logic [MB_W-1:0] xh_size,
  output logic            to_dram
);

  logic [MB_W:0] hole_end;
  logic          below_top;
  logic          in_hole;

  assign hole_end  = {1'b0, xh_base} + {1'b0, xh_size};
  assign below_top = (mb < tom);
  assign in_hole   = xh_en && (mb >= xh_base) && ({1'b0, mb} < hole_end);
  assign to_dram   = below_top && !in_hole;

endmodule

// File: rtl/mem_addr_router.sv
module mem_addr_router
  import mar_pkg::*;
#(
  parameter int unsigned ADDR_W = 36,
  parameter int unsigned CFG_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [2:0]        cfg_idx,
  input  logic [CFG_W-1:0]  cfg_wdata,
  input  logic              req_vld,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_write,
  input  logic              req_master,
  output logic              rsp_vld,
  output logic [1:0]        rsp_dest,
  output logic              rsp_zero
);

  localparam int unsigned MB_W = 12;
  localparam int unsigned MB_LO = 20;

  logic [MB_W-1:0]    tom, xh_base, xh_size;
  logic               low_hole_en, xh_en;
  logic [SEG_CNT-1:0] sh_rd, sh_wr;
  logic               seg_any, seg_rd_en, seg_wr_en;
  logic               ext_dram;

  mar_cfg_regs #(.MB_W(MB_W), .SEG_N(SEG_CNT), .CFG_W(CFG_W)) u_cfg (
    .clk(clk), .rst_n(rst_n),
    .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata),
    .tom(tom), .low_hole_en(low_hole_en), .xh_en(xh_en),
    .xh_base(xh_base), .xh_size(xh_size), .sh_rd(sh_rd), .sh_wr(sh_wr)
  );

  mar_seg_decode #(.SEG_N(SEG_CNT)) u_seg (
    .clk(clk), .rst_n(rst_n),
    .seg_field(req_addr[19:14]), .sh_rd(sh_rd), .sh_wr(sh_wr),
    .seg_any(seg_any), .seg_rd_en(seg_rd_en), .seg_wr_en(seg_wr_en)
  );

  mar_ext_cmp #(.MB_W(MB_W)) u_ext (
    .mb(req_addr[MB_LO+MB_W-1:MB_LO]), .tom(tom), .xh_en(xh_en),
    .xh_base(xh_base), .xh_size(xh_size), .to_dram(ext_dram)
  );

  logic unused_low_addr;
  assign unused_low_addr = ^req_addr[13:0];

  logic  above_4g, below_1m;
  dest_e dest_d;
  logic  zero_d;

  assign above_4g = |req_addr[ADDR_W-1:32];
  assign below_1m = (req_addr[31:20] == '0);

  always_comb begin
    dest_d = DST_PCI;
    if (above_4g) begin
      dest_d = DST_TERM;
    end else if (!below_1m) begin
      dest_d = ext_dram ? DST_DRAM : DST_PCI;
    end else if (!req_addr[19]) begin
      dest_d = DST_DRAM;
    end else if (req_addr[19:17] == 3'b100) begin
      dest_d = low_hole_en ? DST_PCI : DST_DRAM;
    end else if (req_addr[19:17] == 3'b101) begin
      dest_d = DST_PCI;
    end else if (seg_any) begin
      if (req_master && (seg_rd_en || seg_wr_en)) begin
        dest_d = DST_NOCLAIM;
      end else if (req_write) begin
        dest_d = seg_wr_en ? DST_DRAM : DST_PCI;
      end else begin
        dest_d = seg_rd_en ? DST_DRAM : DST_PCI;
      end
    end
  end

  assign zero_d = above_4g && !req_write;

  logic       vld_q;
  logic [1:0] dest_q;
  logic       zero_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
    end else begin
      vld_q <= req_vld;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dest_q <= 2'd0;
      zero_q <= 1'b0;
    end else if (req_vld) begin
      dest_q <= dest_d;
      zero_q <= zero_d;
    end
  end

  assign rsp_vld  = vld_q;
  assign rsp_dest = dest_q;
  assign rsp_zero = zero_q;

  AST_ABOVE_4G_TERM: assert property (@(posedge clk) disable iff (!rst_n)
    (req_vld && above_4g) |=> (rsp_dest == DST_TERM)); // R1
  AST_LOW_DRAM: assert property (@(posedge clk) disable iff (!rst_n)
    (req_vld && req_addr[ADDR_W-1:19] == '0) |=> (rsp_dest == DST_DRAM)); // R2
  AST_VGA_PCI: assert property (@(posedge clk) disable iff (!rst_n)
    (req_vld && req_addr[ADDR_W-1:17] == {{(ADDR_W-20){1'b0}}, 3'b101})
    |=> (rsp_dest == DST_PCI)); // R4
  AST_NOCLAIM_MASTER: assert property (@(posedge clk) disable iff (!rst_n)
    (req_vld && !req_master) |=> (rsp_dest != DST_NOCLAIM)); // R8
  AST_RSP_TIMING: assert property (@(posedge clk) disable iff (!rst_n)
    req_vld |=> rsp_vld); // R9
  AST_RSP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !req_vld |=> !rsp_vld); // R9
  AST_ZERO_TERM_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_zero |-> (rsp_dest == DST_TERM)); // R11

endmodule

// File: tb/mem_addr_router_tb.sv
module mem_addr_router_tb;
  timeunit 1ns;
  timeprecision 1ps;

  logic        clk;
  logic        rst_n;
  logic        cfg_we;
  logic [2:0]  cfg_idx;
  logic [15:0] cfg_wdata;
  logic        req_vld;
  logic [35:0] req_addr;
  logic        req_write;
  logic        req_master;
  logic        rsp_vld;
  logic [1:0]  rsp_dest;
  logic        rsp_zero;

  int n_run;
  int n_fail;

  logic [11:0] m_tom, m_xb, m_xs;
  logic        m_lh, m_xe;
  logic [12:0] m_rd, m_wr;

  mem_addr_router #(.ADDR_W(36), .CFG_W(16)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata),
    .req_vld(req_vld), .req_addr(req_addr), .req_write(req_write),
    .req_master(req_master),
    .rsp_vld(rsp_vld), .rsp_dest(rsp_dest), .rsp_zero(rsp_zero)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic logic [1:0] model_dest(input logic [35:0] a, input logic w, input logic m);
    longint unsigned ua;
    int seg;
    int mb;
    ua = longint'(a);
    if (ua >= 64'h1_0000_0000) return 2'd2;
    if (ua < 64'h80000) return 2'd0;
    if (ua < 64'hA0000) return m_lh ? 2'd1 : 2'd0;
    if (ua < 64'hC0000) return 2'd1;
    if (ua < 64'h100000) begin
      seg = (ua < 64'hF0000) ? int'((ua - 64'hC0000) / 64'h4000) : 12;
      if (m && (m_rd[seg] || m_wr[seg])) return 2'd3;
      if (w) return m_wr[seg] ? 2'd0 : 2'd1;
      return m_rd[seg] ? 2'd0 : 2'd1;
    end
    mb = int'(ua / 64'h100000);
    if (mb < int'(m_tom) &&
        !(m_xe && mb >= int'(m_xb) && mb < int'(m_xb) + int'(m_xs))) return 2'd0;
    return 2'd1;
  endfunction

  task automatic judge(input string tag, input logic [1:0] exp_d, input logic exp_z);
    n_run++;
    if (rsp_vld !== 1'b1 || rsp_dest !== exp_d || rsp_zero !== exp_z) begin
      n_fail++;
      $display("FAIL %s addr=%h: got vld=%b dest=%0d zero=%b, expected vld=1 dest=%0d zero=%b",
               tag, req_addr, rsp_vld, rsp_dest, rsp_zero, exp_d, exp_z);
    end
  endtask

  task automatic do_req(input logic [35:0] a, input logic w, input logic m, input string tag);
    logic [1:0] ed;
    @(negedge clk);
    req_vld = 1'b1; req_addr = a; req_write = w; req_master = m;
    ed = model_dest(a, w, m);
    @(posedge clk);
    #1;
    judge(tag, ed, (ed == 2'd2) && !w);
    @(negedge clk);
    req_vld = 1'b0;
  endtask

  task automatic wr_cfg(input logic [2:0] idx, input logic [15:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_idx = idx; cfg_wdata = d;
    @(posedge clk);
    @(negedge clk);
    cfg_we = 1'b0;
    case (idx)
      3'd0: m_tom = d[11:0];
      3'd1: begin m_lh = d[0]; m_xe = d[1]; end
      3'd2: m_xb = d[11:0];
      3'd3: m_xs = d[11:0];
      3'd4: m_rd = d[12:0];
      3'd5: m_wr = d[12:0];
      default: ;
    endcase
  endtask

  function automatic string region_tag(input logic [35:0] a);
    if (a < 36'h80000) return "R2";
    if (a < 36'hA0000) return "R3";
    if (a < 36'hC0000) return "R4";
    return "R5/R6/R8";
  endfunction

  task automatic sweep_legacy();
    for (int s = 0; s < 64; s++) begin
      for (int k = 0; k < 4; k++) begin
        do_req(36'(s) * 36'h4000 + 36'h1230, k[0], k[1], region_tag(36'(s) * 36'h4000));
      end
    end
  endtask

  task automatic sweep_shadow();
    for (int s = 48; s < 64; s++) begin
      for (int k = 0; k < 4; k++) begin
        do_req(36'(s) * 36'h4000 + 36'h3FFF, k[0], k[1], "R5/R6/R8");
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    n_run = 0; n_fail = 0;
    m_tom = 12'd1; m_xb = '0; m_xs = '0; m_lh = 1'b0; m_xe = 1'b0; m_rd = '0; m_wr = '0;
    rst_n = 1'b0; cfg_we = 1'b0; cfg_idx = '0; cfg_wdata = '0;
    req_vld = 1'b0; req_addr = '0; req_write = 1'b0; req_master = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    n_run++;
    if (rsp_vld !== 1'b0 || rsp_zero !== 1'b0) begin
      n_fail++;
      $display("FAIL R10 reset: got vld=%b zero=%b, expected 0 0", rsp_vld, rsp_zero);
    end
    @(negedge clk);
    rst_n = 1'b1;

    // R10: defaults, every legacy 16 KB step, and 1 MB top
    sweep_legacy();
    do_req(36'h0010_0000, 1'b0, 1'b0, "R10 tom default");
    do_req(36'h0200_0000, 1'b1, 1'b0, "R10 tom default");

    // R9: idle cycle gives no response
    @(negedge clk);
    @(posedge clk);
    #1;
    n_run++;
    if (rsp_vld !== 1'b0) begin
      n_fail++;
      $display("FAIL R9 idle: got vld=%b, expected 0", rsp_vld);
    end

    // R1: above 4 GB
    do_req(36'h1_0000_0000, 1'b0, 1'b0, "R1 read");
    do_req(36'h1_0000_0000, 1'b1, 1'b0, "R1 write");
    do_req(36'hF_FFFF_FFFF, 1'b0, 1'b1, "R1 master read");
    do_req(36'h0_FFFF_FFFF, 1'b0, 1'b0, "R7 below 4G");

    // R10: register write in the same cycle as a request uses the old value
    @(negedge clk);
    cfg_we = 1'b1; cfg_idx = 3'd1; cfg_wdata = 16'h0001;
    req_vld = 1'b1; req_addr = 36'h90000; req_write = 1'b0; req_master = 1'b0;
    @(posedge clk);
    #1;
    judge("R10 same-cycle write", 2'd0, 1'b0);
    @(negedge clk);
    cfg_we = 1'b0;
    m_lh = 1'b1;
    req_vld = 1'b0;
    do_req(36'h90000, 1'b0, 1'b0, "R3 hole after write");

    // Mixed configuration
    wr_cfg(3'd4, 16'h0A5A);
    wr_cfg(3'd5, 16'h1333);
    wr_cfg(3'd0, 16'd64);
    wr_cfg(3'd2, 16'd16);
    wr_cfg(3'd3, 16'd8);
    wr_cfg(3'd1, 16'h0003);
    sweep_legacy();
    for (int mb = 1; mb < 80; mb++) begin
      do_req(36'(mb) * 36'h100000 + 36'h5_5550, mb[0], 1'b0, "R7 sweep");
    end
    do_req(36'h03F0_0000, 1'b0, 1'b0, "R7 last MB below top");
    do_req(36'h0400_0000, 1'b0, 1'b0, "R7 top boundary");
    do_req(36'h017F_FFFF, 1'b0, 1'b0, "R7 hole last MB");
    do_req(36'h0180_0000, 1'b0, 1'b0, "R7 hole end");
    do_req(36'h00FF_FFFF, 1'b1, 1'b0, "R7 hole start-1");

    // R6 copy phase: reads from ROM side, writes into DRAM
    wr_cfg(3'd1, 16'h0000);
    wr_cfg(3'd4, 16'h0000);
    wr_cfg(3'd5, 16'h1FFF);
    sweep_shadow();
    do_req(36'h90000, 1'b1, 1'b0, "R3 hole off");

    // R6 locked phase: reads from DRAM, writes away from DRAM
    wr_cfg(3'd4, 16'h1FFF);
    wr_cfg(3'd5, 16'h0000);
    sweep_shadow();

    // R8: disabled segments are still claimed normally by masters
    wr_cfg(3'd4, 16'h1000);
    sweep_shadow();

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule